// File: doc/BRIEF.md
# Audio Serial Port Event and Interrupt Unit

This unit gathers the event strobes of a serial audio port's datapath into one status word, holds the error and event strobes as sticky flags, and drives a single interrupt line. Software sees three word locations through a small register port. The first is a read-only status word. The second is a writable interrupt enable mask. The third is a write-one-to-clear location that acknowledges sticky flags.

The status word mixes two kinds of bits. Live levels come straight from the datapath: receive data ready, transmit room, a two-bit receive fill level and a receive-word-pending flag. Sticky flags are set by single-cycle strobes: end of transfer, underrun, overrun, frame error, mode fault and suspended. The interrupt line is high while any status bit is set whose enable bit is also set.

Top module: `aport_irq_unit`

## Requirements
- R1: After reset all sticky flags and all enable bits are zero, and `irq_o` is low.
- R2: Status bit 0 follows `rx_avail_i`, bit 1 follows `tx_space_i`, bits 14:13 follow `rx_level_i` and bit 15 follows `rx_word_ne_i`, all in the same cycle. A write to the clear location does not change them.
- R3: A one on `evt_i` at a sticky position sets that flag one clock later. The sticky positions are bit 3 end of transfer, 5 underrun, 6 overrun, 8 frame error, 9 mode fault and 11 suspended. The flag then holds until it is cleared or reset.
- R4: A one on `evt_i` at any non-sticky position (0, 1, 2, 4, 7, 10, 12 to 15) has no effect on the status word.
- R5: A write to address 2 clears each sticky flag in bits 11:3 whose data bit is one, one clock later. Data bits that are zero leave their flags alone, and data bits outside 11:3 are ignored.
- R6: When a clear write and an event strobe hit the same flag in the same cycle, the flag is set after that edge.
- R7: Address 1 holds an 11-bit enable mask. A write stores data bits 10:0, and a read returns them in bits 10:0 with zeros above.
- R8: `irq_o` is the OR over bits 10:0 of status AND enable, and it follows both without an extra register. Suspended (bit 11) has no enable bit and never raises `irq_o`.
- R9: Address 2 and address 3 read as zero. Reads never change any state. Writes to address 0 or address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 2 | Word select: 0 status, 1 enable, 2 clear, 3 unused |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected word, combinational |
| rx_avail_i | input | 1 | Live level: receive data ready |
| tx_space_i | input | 1 | Live level: transmit room available |
| rx_level_i | input | 2 | Live level: receive fill level |
| rx_word_ne_i | input | 1 | Live level: receive word pending |
| evt_i | input | 16 | Single-cycle event strobes at status bit positions |
| irq_o | output | 1 | Interrupt request |

## Verification
A clear write from software and a strobe from the datapath can land on the same sticky flag in the same cycle. The bench provokes this by driving an overrun strobe in the cycle that writes the overrun clear bit. It then reads the status word and expects the flag to still be set. A second overlap is an enable write meeting a flag that is already set: the bench reads `irq_o` in the cycle after the enable write and expects it high at once, and it expects the suspended flag never to raise it.

// File: rtl/aport_irq_pkg.sv
package aport_irq_pkg;
  localparam int STAT_W = 16;
  localparam int EN_W   = 11;
  localparam int ADDR_W = 2;

  // sticky flag positions: 3,5,6,8,9,11
  localparam logic [STAT_W-1:0] STICKY_MASK = 16'h0B68;
  // clear register reach: bits 11:3
  localparam logic [STAT_W-1:0] CLR_MASK    = 16'h0FF8;

  localparam int RX_AVAIL_BIT = 0;
  localparam int TX_SPACE_BIT = 1;
  localparam int RX_LVL_LSB   = 13;
  localparam int RX_WNE_BIT   = 15;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // event strobes win over clears on the same bit
  function automatic logic [STAT_W-1:0] sticky_next(
      input logic [STAT_W-1:0] cur,
      input logic [STAT_W-1:0] evt,
      input logic [STAT_W-1:0] clr);
    return ((cur & ~(clr & CLR_MASK)) | evt) & STICKY_MASK;
  endfunction

  function automatic logic [STAT_W-1:0] live_bits(
      input logic       rx_avail,
      input logic       tx_space,
      input logic [1:0] rx_level,
      input logic       rx_wne);
    logic [STAT_W-1:0] v;
    v = '0;
    v[RX_AVAIL_BIT]            = rx_avail;
    v[TX_SPACE_BIT]            = tx_space;
    v[RX_LVL_LSB +: 2]         = rx_level;
    v[RX_WNE_BIT]              = rx_wne;
    return v;
  endfunction

  function automatic logic irq_any(
      input logic [STAT_W-1:0] stat,
      input logic [EN_W-1:0]   en);
    return |(stat[EN_W-1:0] & en);
  endfunction
endpackage

// File: rtl/aport_sticky_bank.sv
module aport_sticky_bank
  import aport_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              clr_strobe_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] sticky_o
);
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] sticky_d;
  logic [STAT_W-1:0] sticky_q;

  assign clr_vec  = clr_strobe_i ? clr_data_i : '0;
  assign sticky_d = sticky_next(sticky_q, evt_i, clr_vec);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/aport_enable_reg.sv
module aport_enable_reg
  import aport_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] en_o
);
  logic [EN_W-1:0] en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/aport_read_mux.sv
module aport_read_mux
  import aport_irq_pkg::*;
(
  input  reg_sel_e          sel_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [EN_W-1:0]   en_i,
  output logic [STAT_W-1:0] rdata_o
);
  localparam int PAD_W = STAT_W - EN_W;

  always_comb begin
    unique case (sel_i)
      SEL_STATUS: rdata_o = status_i;
      SEL_ENABLE: rdata_o = {{PAD_W{1'b0}}, en_i};
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aport_irq_unit.sv
module aport_irq_unit
  import aport_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  input  logic              rx_avail_i,
  input  logic              tx_space_i,
  input  logic [1:0]        rx_level_i,
  input  logic              rx_word_ne_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              en_strobe;
  logic              clr_strobe;
  logic [STAT_W-1:0] sticky_q;
  logic [EN_W-1:0]   en_q;
  logic [STAT_W-1:0] status_w;

  assign sel        = reg_sel_e'(reg_addr_i);
  assign en_strobe  = reg_wr_i && (sel == SEL_ENABLE);
  assign clr_strobe = reg_wr_i && (sel == SEL_CLEAR);

  aport_sticky_bank u_sticky (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .clr_strobe_i (clr_strobe),
    .clr_data_i   (reg_wdata_i),
    .sticky_o     (sticky_q)
  );

  aport_enable_reg u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (en_strobe),
    .wdata_i (reg_wdata_i[EN_W-1:0]),
    .en_o    (en_q)
  );

  assign status_w = sticky_q | live_bits(rx_avail_i, tx_space_i, rx_level_i, rx_word_ne_i);

  aport_read_mux u_rmux (
    .sel_i    (sel),
    .status_i (status_w),
    .en_i     (en_q),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = irq_any(status_w, en_q);
endmodule

// File: rtl/aport_irq_chk.sv
module aport_irq_chk
  import aport_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [STAT_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] reg_rdata_o,
  input logic [STAT_W-1:0] evt_i,
  input logic              rx_avail_i,
  input logic [STAT_W-1:0] sticky_q,
  input logic [EN_W-1:0]   en_q,
  input logic              irq_o
);
  logic clr_wr;
  assign clr_wr = reg_wr_i && (reg_addr_i == 2'd2);

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sticky_q == '0 && en_q == '0));

  assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & STICKY_MASK) != '0) |=>
      ((sticky_q & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr && (evt_i & STICKY_MASK) == '0) |=> $stable(sticky_q));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((sticky_q & $past(reg_wdata_i & CLR_MASK & ~evt_i)) == '0));

  assert_no_en_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  assert_live_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_avail_i && en_q[0]) |-> irq_o);

  assert_clear_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd2) |-> (reg_rdata_o == '0));
endmodule

bind aport_irq_unit aport_irq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .evt_i       (evt_i),
  .rx_avail_i  (rx_avail_i),
  .sticky_q    (sticky_q),
  .en_q        (en_q),
  .irq_o       (irq_o)
);

// File: tb/aport_irq_unit_tb.sv
module aport_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        rx_avail = 1'b0;
  logic        tx_space = 1'b0;
  logic [1:0]  rx_level = 2'b00;
  logic        rx_word_ne = 1'b0;
  logic [15:0] evt = 16'h0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  aport_irq_unit dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .reg_addr_i   (reg_addr),
    .reg_wr_i     (reg_wr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .rx_avail_i   (rx_avail),
    .tx_space_i   (tx_space),
    .rx_level_i   (rx_level),
    .rx_word_ne_i (rx_word_ne),
    .evt_i        (evt),
    .irq_o        (irq)
  );

  localparam logic [15:0] STICKY = 16'h0B68;

  // {event, clear data, expected sticky bits after the step}
  localparam int NVEC = 10;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0008, 16'h0000, 16'h0008},  // R3 end of transfer
    {16'h0060, 16'h0000, 16'h0068},  // R3 underrun+overrun
    {16'h0B00, 16'h0000, 16'h0B68},  // R3 frame, mode, suspend
    {16'h0000, 16'h0020, 16'h0B48},  // R5 clear underrun only
    {16'h0040, 16'h0040, 16'h0B48},  // R6 event beats clear
    {16'h4497, 16'h0000, 16'h0B48},  // R4 non-sticky strobes ignored
    {16'h0000, 16'hF007, 16'h0B48},  // R5 out-of-range clear bits ignored
    {16'h0000, 16'h0FF8, 16'h0000},  // R5 clear all
    {16'h0A28, 16'h0000, 16'h0A28},  // R3 mixed set
    {16'h0000, 16'h0808, 16'h0220}   // R5 partial clear
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = 16'h0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=hung expected=done");
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] d2;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 16'h0000);
    rd(2'd1, d); check("R1 enable", d, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      evt = VEC[i][47:32];
      if (VEC[i][31:16] != 16'h0) begin
        reg_addr = 2'd2; reg_wdata = VEC[i][31:16]; reg_wr = 1'b1;
      end
      @(negedge clk);
      evt = 16'h0; reg_wr = 1'b0; reg_wdata = 16'h0;
      rd(2'd0, d);
      check($sformatf("R3/R4/R5/R6 step %0d", i), d & STICKY, VEC[i][15:0]);
    end

    // R2 live levels, not clearable
    wr(2'd2, 16'h0FF8);
    rx_avail = 1'b1; tx_space = 1'b1; rx_level = 2'b10; rx_word_ne = 1'b1;
    rd(2'd0, d); check("R2 live bits", d, 16'hC003);
    wr(2'd2, 16'hFFFF);
    rd(2'd0, d); check("R2 after clear", d, 16'hC003);
    rx_level = 2'b01; rx_word_ne = 1'b0; tx_space = 1'b0;
    rd(2'd0, d); check("R2 follow", d, 16'h2001);
    rx_avail = 1'b0; rx_level = 2'b00;

    // R7 enable width
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R7 enable readback", d, 16'h07FF);
    wr(2'd1, 16'h0525);
    rd(2'd1, d); check("R7 enable pattern", d, 16'h0525);

    // R8 suspend never interrupts
    wr(2'd1, 16'h07FF);
    pulse(16'h0800);
    rd(2'd0, d); check("R8 suspend set", d, 16'h0800);
    check("R8 suspend no irq", {15'b0, irq}, 16'h0000);
    pulse(16'h0008);
    check("R8 irq on eot", {15'b0, irq}, 16'h0001);
    wr(2'd1, 16'h0000);
    check("R8 irq masked", {15'b0, irq}, 16'h0000);
    wr(2'd1, 16'h0008);
    check("R8 irq on enable", {15'b0, irq}, 16'h0001);
    wr(2'd2, 16'h0008);
    check("R8 irq after clear", {15'b0, irq}, 16'h0000);
    rx_avail = 1'b1;
    wr(2'd1, 16'h0001);
    check("R8 live irq", {15'b0, irq}, 16'h0001);
    rx_avail = 1'b0;
    #1 check("R8 live irq drops", {15'b0, irq}, 16'h0000);

    // R9 reads and ignored writes
    rd(2'd2, d); check("R9 clear reads zero", d, 16'h0000);
    rd(2'd3, d); check("R9 addr3 reads zero", d, 16'h0000);
    rd(2'd0, d);
    @(negedge clk);
    rd(2'd0, d2); check("R9 read no side effect", d2, d);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d2); check("R9 status write ignored", d2, 16'h0800);
    wr(2'd3, 16'hFFFF);
    rd(2'd1, d2); check("R9 addr3 write ignored", d2, 16'h0001);

    // R1 reset again mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(2'd0, d); check("R1 status after reset", d, 16'h0000);
    rd(2'd1, d); check("R1 enable after reset", d, 16'h0000);

    finish_run();
  end
endmodule